// File: doc/BRIEF.md
# Partitioned Shared-RAM FIFO Manager

This block takes one byte-wide RAM and divides it at run time into a transmit FIFO and a receive FIFO for each of three serial clients: SPI (client 0), UART (client 1) and I2C (client 2). A 4-bit split code, loaded with a one-cycle write strobe, chooses how the RAM is shared among the clients in quarter steps. The block derives every region's base address and capacity from the code and keeps the read and write offsets and the fill level of all six FIFOs. It serialises every byte access onto one RAM port.

The host pushes into the TX FIFOs and pops from the RX FIFOs. The protocol engines pop TX and push RX. Each operation is a request held high until its acknowledge appears. Pushes complete in the acknowledged cycle. Popped bytes appear on a shared return bus one cycle after the acknowledge, with a per-FIFO valid pulse. The UART receive path stores a status byte next to every data byte. Because of this, the UART share is cut into three equal areas and holds about two thirds of its share as data.

Top module: `shram_fifo_hub`

## Requirements
- R1: After reset the split code is 0h. Every level is 0, every empty flag is 1 and every full flag is 1.
- R2: The split code gives SPI/UART/I2C shares in quarters of the RAM as follows: 1h=0/4/0, 2h=1/3/0, 3h=2/2/0, 4h=3/1/0, 5h=4/0/0, 6h=0/0/4, 7h=0/1/3, 8h=0/2/2, 9h=0/3/1, Ah=1/0/3, Bh=2/0/2, Ch=3/0/1. Codes 0h and Dh-Fh allocate nothing. For SPI and I2C, both the TX FIFO and the RX FIFO hold half the client's share. A FIFO reports full exactly when its level equals its capacity.
- R3: The UART TX capacity and the UART RX data capacity are both one third of the UART share, rounded down to a multiple of 4. The RX status area has that same size.
- R4: Each FIFO returns bytes in the order they were pushed. This holds when its offsets wrap at the end of its own region.
- R5: Regions are placed in the order SPI, UART, I2C from address 0. Within a client the order is TX, RX, then UART status. Regions never overlap, so filling every FIFO to capacity corrupts none of them.
- R6: A UART RX push stores the data byte and the status byte. A UART RX pop returns both together, on `rd_byte` and `rd_stat`.
- R7: A push to a full FIFO or a pop from an empty FIFO is never acknowledged and changes no level. A client with zero capacity is full and empty at once.
- R8: A write strobe on the code empties every FIFO: all levels read 0 in the next cycle. No request is acknowledged in the strobe cycle.
- R9: The RAM port serves at most one access per cycle. Pending requests are granted round-robin, so requesters that hold their requests continuously receive equal service.
- R10: A single-access operation is acknowledged in its grant cycle. A UART RX push or pop uses two consecutive accesses and is acknowledged in the second. Pop data is valid in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load split code and flush all FIFOs |
| cfg_code | input | 4 | Split code |
| tx_push_req | input | 3 | Host push request per client TX FIFO |
| tx_push_data | input | 3x8 | Host push byte per client |
| tx_push_ack | output | 3 | TX push done |
| tx_pop_req | input | 3 | Engine pop request per client TX FIFO |
| tx_pop_ack | output | 3 | TX pop granted |
| tx_pop_vld | output | 3 | TX pop byte valid on `rd_byte` |
| rx_push_req | input | 3 | Engine push request per client RX FIFO |
| rx_push_data | input | 3x8 | Engine push byte per client |
| rx_push_stat | input | 8 | UART receive status byte |
| rx_push_ack | output | 3 | RX push done |
| rx_pop_req | input | 3 | Host pop request per client RX FIFO |
| rx_pop_ack | output | 3 | RX pop granted |
| rx_pop_vld | output | 3 | RX pop byte valid on `rd_byte` |
| rd_byte | output | 8 | Returned data byte |
| rd_stat | output | 8 | Returned UART status byte, 0 otherwise |
| tx_full | output | 3 | TX FIFO full |
| tx_empty | output | 3 | TX FIFO empty |
| tx_level | output | 3xLW | TX FIFO fill level |
| rx_full | output | 3 | RX FIFO full |
| rx_empty | output | 3 | RX FIFO empty |
| rx_level | output | 3xLW | RX FIFO fill level |

## Verification
The hardest case to reach is every region holding its full capacity at once, with its offsets part-way around. This is the only state in which an error in the base arithmetic or in the UART one-third rounding shows up as overwritten data. The bench reaches it for every one of the sixteen codes, on a small RAM. First it pushes and pops three bytes in each FIFO so the offsets sit off zero. Next it fills all six FIFOs until each reports full. Only then does it drain them and compare every byte and status byte.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int NCLI     = 3;
  localparam int CLI_SPI  = 0;
  localparam int CLI_UART = 1;
  localparam int CLI_I2C  = 2;
  localparam int NOPS     = 4;

  // operation slot within a client's group of request sources
  typedef enum logic [1:0] {
    OP_TX_WR = 2'd0,
    OP_TX_RD = 2'd1,
    OP_RX_WR = 2'd2,
    OP_RX_RD = 2'd3
  } op_e;

  // shares in quarters of the RAM (0..4)
  typedef struct packed {
    logic [2:0] spi;
    logic [2:0] uart;
    logic [2:0] i2c;
  } share_t;

  function automatic share_t split_of(input logic [3:0] code);
    share_t s;
    s = '0;
    case (code)
      4'h1: s = '{spi: 3'd0, uart: 3'd4, i2c: 3'd0};
      4'h2: s = '{spi: 3'd1, uart: 3'd3, i2c: 3'd0};
      4'h3: s = '{spi: 3'd2, uart: 3'd2, i2c: 3'd0};
      4'h4: s = '{spi: 3'd3, uart: 3'd1, i2c: 3'd0};
      4'h5: s = '{spi: 3'd4, uart: 3'd0, i2c: 3'd0};
      4'h6: s = '{spi: 3'd0, uart: 3'd0, i2c: 3'd4};
      4'h7: s = '{spi: 3'd0, uart: 3'd1, i2c: 3'd3};
      4'h8: s = '{spi: 3'd0, uart: 3'd2, i2c: 3'd2};
      4'h9: s = '{spi: 3'd0, uart: 3'd3, i2c: 3'd1};
      4'hA: s = '{spi: 3'd1, uart: 3'd0, i2c: 3'd3};
      4'hB: s = '{spi: 3'd2, uart: 3'd0, i2c: 3'd2};
      4'hC: s = '{spi: 3'd3, uart: 3'd0, i2c: 3'd1};
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/shram_layout.sv
module shram_layout
  import shram_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int AW        = 11,
  parameter int LW        = 11
) (
  input  share_t                  share,
  output logic [NCLI-1:0][AW-1:0] tx_base,
  output logic [NCLI-1:0][AW-1:0] rx_base,
  output logic [AW-1:0]           stat_base,
  output logic [NCLI-1:0][LW-1:0] cap
);
  localparam int QTR = MEM_BYTES / 4;

  int q_spi, q_uart, q_i2c, u_cap;

  always_comb begin
    q_spi  = int'(share.spi) * QTR;
    q_uart = int'(share.uart) * QTR;
    q_i2c  = int'(share.i2c) * QTR;
    u_cap  = q_uart / 3;
    u_cap  = u_cap - (u_cap % 4);

    cap[CLI_SPI]      = LW'(q_spi / 2);
    tx_base[CLI_SPI]  = '0;
    rx_base[CLI_SPI]  = AW'(q_spi / 2);

    cap[CLI_UART]     = LW'(u_cap);
    tx_base[CLI_UART] = AW'(q_spi);
    rx_base[CLI_UART] = AW'(q_spi + u_cap);
    stat_base         = AW'(q_spi + 2 * u_cap);

    cap[CLI_I2C]      = LW'(q_i2c / 2);
    tx_base[CLI_I2C]  = AW'(q_spi + q_uart);
    rx_base[CLI_I2C]  = AW'(q_spi + q_uart + q_i2c / 2);
  end
endmodule

// File: rtl/shram_fifo_ctr.sv
module shram_fifo_ctr #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] cap,
  output logic [LW-1:0] wr_off,
  output logic [LW-1:0] rd_off,
  output logic [LW-1:0] level
);
  logic [LW-1:0] wr_n, rd_n, lvl_n;
  logic          en;

  always_comb begin
    wr_n  = wr_off;
    rd_n  = rd_off;
    lvl_n = level;
    if (push) wr_n = (({1'b0, wr_off} + 1'b1) == {1'b0, cap}) ? '0 : wr_off + 1'b1;
    if (pop)  rd_n = (({1'b0, rd_off} + 1'b1) == {1'b0, cap}) ? '0 : rd_off + 1'b1;
    case ({push, pop})
      2'b10:   lvl_n = level + 1'b1;
      2'b01:   lvl_n = level - 1'b1;
      default: lvl_n = level;
    endcase
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      lvl_n = '0;
    end
  end

  assign en = flush | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      level  <= '0;
    end else if (en) begin
      wr_off <= wr_n;
      rd_off <= rd_n;
      level  <= lvl_n;
    end
  end
endmodule

// File: rtl/shram_rr_arb.sv
module shram_rr_arb #(
  parameter int N = 12,
  parameter logic [N-1:0] TWO_PH = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         phase
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic          busy_q, busy_n;
  logic [SW-1:0] cur_q, cur_n;
  logic [SW-1:0] last_q, last_n;
  logic          found;
  int            idx;

  always_comb begin
    grant  = '0;
    phase  = 1'b0;
    busy_n = busy_q;
    cur_n  = cur_q;
    last_n = last_q;
    found  = 1'b0;
    idx    = 0;
    if (flush) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      grant[cur_q] = 1'b1;
      phase        = 1'b1;
      busy_n       = 1'b0;
    end else begin
      for (int off = 1; off <= N; off++) begin
        idx = int'(last_q) + off;
        if (idx >= N) idx = idx - N;
        if (!found && req[idx]) begin
          found      = 1'b1;
          grant[idx] = 1'b1;
          last_n     = SW'(idx);
          if (TWO_PH[idx]) begin
            busy_n = 1'b1;
            cur_n  = SW'(idx);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= SW'(N - 1);
    end else begin
      busy_q <= busy_n;
      cur_q  <= cur_n;
      last_q <= last_n;
    end
  end
endmodule

// File: rtl/shram_bytes.sv
module shram_bytes #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/shram_fifo_hub.sv
module shram_fifo_hub
  import shram_pkg::*;
#(
  parameter  int MEM_BYTES = 2048,
  localparam int AW        = $clog2(MEM_BYTES),
  localparam int LW        = $clog2(MEM_BYTES / 2 + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_code,
  input  logic [2:0]             tx_push_req,
  input  logic [2:0][7:0]        tx_push_data,
  output logic [2:0]             tx_push_ack,
  input  logic [2:0]             tx_pop_req,
  output logic [2:0]             tx_pop_ack,
  output logic [2:0]             tx_pop_vld,
  input  logic [2:0]             rx_push_req,
  input  logic [2:0][7:0]        rx_push_data,
  input  logic [7:0]             rx_push_stat,
  output logic [2:0]             rx_push_ack,
  input  logic [2:0]             rx_pop_req,
  output logic [2:0]             rx_pop_ack,
  output logic [2:0]             rx_pop_vld,
  output logic [7:0]             rd_byte,
  output logic [7:0]             rd_stat,
  output logic [2:0]             tx_full,
  output logic [2:0]             tx_empty,
  output logic [2:0][LW-1:0]     tx_level,
  output logic [2:0]             rx_full,
  output logic [2:0]             rx_empty,
  output logic [2:0][LW-1:0]     rx_level
);
  localparam int NSRC = NCLI * NOPS;
  localparam logic [NSRC-1:0] TWO_PH =
    (NSRC'(1) << (CLI_UART * NOPS + int'(OP_RX_WR))) |
    (NSRC'(1) << (CLI_UART * NOPS + int'(OP_RX_RD)));
  localparam int HOLD_SRC = CLI_UART * NOPS + int'(OP_RX_RD);

  logic [3:0]              code_q;
  share_t                  share;
  logic [NCLI-1:0][AW-1:0] tx_base, rx_base;
  logic [AW-1:0]           stat_base;
  logic [NCLI-1:0][LW-1:0] cap;
  logic [NCLI-1:0][LW-1:0] tx_wr, tx_rd, rx_wr, rx_rd;
  logic [NSRC-1:0]         req, arb_grant, done;
  logic                    arb_phase;
  logic                    ram_we, ram_re;
  logic [AW-1:0]           ram_addr;
  logic [7:0]              ram_wdata, ram_q;
  logic [2:0]              ret_tx_n, ret_rx_n;
  logic                    ret_pair_n, ret_pair_q, hold_en;
  logic [7:0]              hold_q;

  // split code register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= 4'h0;
    else if (cfg_we) code_q <= cfg_code;
  end

  assign share = split_of(code_q);

  shram_layout #(.MEM_BYTES(MEM_BYTES), .AW(AW), .LW(LW)) u_layout (
    .share(share), .tx_base(tx_base), .rx_base(rx_base),
    .stat_base(stat_base), .cap(cap)
  );

  for (genvar c = 0; c < NCLI; c++) begin : g_cli
    localparam int S = c * NOPS;

    shram_fifo_ctr #(.LW(LW)) u_tx (
      .clk(clk), .rst_n(rst_n), .flush(cfg_we),
      .push(done[S + int'(OP_TX_WR)]), .pop(done[S + int'(OP_TX_RD)]),
      .cap(cap[c]), .wr_off(tx_wr[c]), .rd_off(tx_rd[c]), .level(tx_level[c])
    );

    shram_fifo_ctr #(.LW(LW)) u_rx (
      .clk(clk), .rst_n(rst_n), .flush(cfg_we),
      .push(done[S + int'(OP_RX_WR)]), .pop(done[S + int'(OP_RX_RD)]),
      .cap(cap[c]), .wr_off(rx_wr[c]), .rd_off(rx_rd[c]), .level(rx_level[c])
    );

    assign tx_full[c]  = (tx_level[c] == cap[c]);
    assign rx_full[c]  = (rx_level[c] == cap[c]);
    assign tx_empty[c] = (tx_level[c] == '0);
    assign rx_empty[c] = (rx_level[c] == '0);

    assign req[S + int'(OP_TX_WR)] = tx_push_req[c] & ~tx_full[c];
    assign req[S + int'(OP_TX_RD)] = tx_pop_req[c]  & ~tx_empty[c];
    assign req[S + int'(OP_RX_WR)] = rx_push_req[c] & ~rx_full[c];
    assign req[S + int'(OP_RX_RD)] = rx_pop_req[c]  & ~rx_empty[c];

    assign tx_push_ack[c] = done[S + int'(OP_TX_WR)];
    assign tx_pop_ack[c]  = done[S + int'(OP_TX_RD)];
    assign rx_push_ack[c] = done[S + int'(OP_RX_WR)];
    assign rx_pop_ack[c]  = done[S + int'(OP_RX_RD)];

    assign ret_tx_n[c] = done[S + int'(OP_TX_RD)];
    assign ret_rx_n[c] = done[S + int'(OP_RX_RD)];
  end

  shram_rr_arb #(.N(NSRC), .TWO_PH(TWO_PH)) u_arb (
    .clk(clk), .rst_n(rst_n), .flush(cfg_we), .req(req),
    .grant(arb_grant), .phase(arb_phase)
  );

  // an operation completes on its only access, or on the second of two
  assign done = arb_grant & (~TWO_PH | {NSRC{arb_phase}});

  // RAM port steering
  always_comb begin
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (arb_grant[s]) begin
        case (op_e'(s % NOPS))
          OP_TX_WR: begin
            ram_we    = 1'b1;
            ram_addr  = tx_base[s / NOPS] + AW'(tx_wr[s / NOPS]);
            ram_wdata = tx_push_data[s / NOPS];
          end
          OP_TX_RD: begin
            ram_re   = 1'b1;
            ram_addr = tx_base[s / NOPS] + AW'(tx_rd[s / NOPS]);
          end
          OP_RX_WR: begin
            ram_we = 1'b1;
            if (arb_phase) begin
              ram_addr  = stat_base + AW'(rx_wr[s / NOPS]);
              ram_wdata = rx_push_stat;
            end else begin
              ram_addr  = rx_base[s / NOPS] + AW'(rx_wr[s / NOPS]);
              ram_wdata = rx_push_data[s / NOPS];
            end
          end
          default: begin
            ram_re   = 1'b1;
            ram_addr = (arb_phase ? stat_base : rx_base[s / NOPS]) + AW'(rx_rd[s / NOPS]);
          end
        endcase
      end
    end
  end

  shram_bytes #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  // read return: data byte of a paired pop is parked while its status is read
  assign ret_pair_n = done[HOLD_SRC];
  assign hold_en    = arb_grant[HOLD_SRC] & arb_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pop_vld <= '0;
      rx_pop_vld <= '0;
      ret_pair_q <= 1'b0;
    end else begin
      tx_pop_vld <= ret_tx_n;
      rx_pop_vld <= ret_rx_n;
      ret_pair_q <= ret_pair_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= ram_q;
  end

  assign rd_byte = ret_pair_q ? hold_q : ram_q;
  assign rd_stat = ret_pair_q ? ram_q  : 8'h00;
endmodule

// File: rtl/shram_fifo_hub_chk.sv
module shram_fifo_hub_chk #(
  parameter int LW = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [11:0]         grant,
  input logic [2:0][LW-1:0]  cap,
  input logic [2:0]          tx_push_ack,
  input logic [2:0]          tx_pop_ack,
  input logic [2:0]          rx_push_ack,
  input logic [2:0]          rx_pop_ack,
  input logic [2:0]          tx_pop_vld,
  input logic [2:0]          rx_pop_vld,
  input logic [2:0]          tx_full,
  input logic [2:0]          tx_empty,
  input logic [2:0]          rx_full,
  input logic [2:0]          rx_empty,
  input logic [2:0][LW-1:0]  tx_level,
  input logic [2:0][LW-1:0]  rx_level
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_push_ack & tx_full) == 3'b000) && ((rx_push_ack & rx_full) == 3'b000)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_pop_ack & tx_empty) == 3'b000) && ((rx_pop_ack & rx_empty) == 3'b000)); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> ({tx_push_ack, tx_pop_ack, rx_push_ack, rx_pop_ack} == 12'h000)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (tx_empty == 3'b111) && (rx_empty == 3'b111)); // R8

  AST_TX_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_ack != 3'b000) |=> (tx_pop_vld == $past(tx_pop_ack))); // R10

  AST_RX_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_ack != 3'b000) |=> (rx_pop_vld == $past(rx_pop_ack))); // R10

  for (genvar c = 0; c < 3; c++) begin : g_c
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level[c] <= cap[c]) && (rx_level[c] <= cap[c])); // R2

    AST_ZERO_CLIENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cap[c] == '0) |-> (tx_full[c] && tx_empty[c] && rx_full[c] && rx_empty[c])); // R7
  end
endmodule

bind shram_fifo_hub shram_fifo_hub_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .grant(arb_grant), .cap(cap),
  .tx_push_ack(tx_push_ack), .tx_pop_ack(tx_pop_ack),
  .rx_push_ack(rx_push_ack), .rx_pop_ack(rx_pop_ack),
  .tx_pop_vld(tx_pop_vld), .rx_pop_vld(rx_pop_vld),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/shram_fifo_hub_test.sv
`timescale 1ns/1ps
module shram_fifo_hub_test;
  localparam int MEM = 256;
  localparam int Q   = MEM / 4;
  localparam int LW  = $clog2(MEM / 2 + 1);

  logic clk, rst_n, cfg_we;
  logic [3:0] cfg_code;
  logic [2:0] tx_push_req, tx_pop_req, rx_push_req, rx_pop_req;
  logic [2:0][7:0] tx_push_data, rx_push_data;
  logic [7:0] rx_push_stat, rd_byte, rd_stat;
  logic [2:0] tx_push_ack, tx_pop_ack, tx_pop_vld, rx_push_ack, rx_pop_ack, rx_pop_vld;
  logic [2:0] tx_full, tx_empty, rx_full, rx_empty;
  logic [2:0][LW-1:0] tx_level, rx_level;

  int n_chk, n_bad;
  bit done_flag;

  shram_fifo_hub #(.MEM_BYTES(MEM)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .tx_push_req(tx_push_req), .tx_push_data(tx_push_data), .tx_push_ack(tx_push_ack),
    .tx_pop_req(tx_pop_req), .tx_pop_ack(tx_pop_ack), .tx_pop_vld(tx_pop_vld),
    .rx_push_req(rx_push_req), .rx_push_data(rx_push_data), .rx_push_stat(rx_push_stat),
    .rx_push_ack(rx_push_ack), .rx_pop_req(rx_pop_req), .rx_pop_ack(rx_pop_ack),
    .rx_pop_vld(rx_pop_vld), .rd_byte(rd_byte), .rd_stat(rd_stat),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_cap(input int code, input int c);
    int s[3];
    case (code)
      1: s = '{0, 4, 0};  2: s = '{1, 3, 0};  3: s = '{2, 2, 0};
      4: s = '{3, 1, 0};  5: s = '{4, 0, 0};  6: s = '{0, 0, 4};
      7: s = '{0, 1, 3};  8: s = '{0, 2, 2};  9: s = '{0, 3, 1};
      10: s = '{1, 0, 3}; 11: s = '{2, 0, 2}; 12: s = '{3, 0, 1};
      default: s = '{0, 0, 0};
    endcase
    if (c == 1) return ((s[1] * Q) / 3) / 4 * 4;
    return s[c] * Q / 2;
  endfunction

  function automatic logic [7:0] pat(input int code, input int f, input int i);
    return 8'((code * 29 + f * 61 + i * 3 + 5) & 255);
  endfunction

  function automatic int lvl(input int f);
    return (f % 2) ? int'(rx_level[f / 2]) : int'(tx_level[f / 2]);
  endfunction

  task automatic set_code(input int code);
    @(posedge clk); #1;
    cfg_code = 4'(code);
    cfg_we   = 1'b1;
    @(posedge clk); #1;
    cfg_we   = 1'b0;
  endtask

  // push into fifo f (even: TX of client f/2, odd: RX)
  task automatic do_push(input int f, input int code, input int i, input int maxw,
                         output bit acked, output int waits);
    int c;
    c = f / 2;
    @(posedge clk); #1;
    if (f % 2) begin
      rx_push_req[c] = 1'b1; rx_push_data[c] = pat(code, f, i); rx_push_stat = ~pat(code, f, i);
    end else begin
      tx_push_req[c] = 1'b1; tx_push_data[c] = pat(code, f, i);
    end
    acked = 1'b0; waits = 0;
    while (!acked && waits < maxw) begin
      @(negedge clk);
      if ((f % 2) ? rx_push_ack[c] : tx_push_ack[c]) acked = 1'b1;
      else waits++;
      @(posedge clk); #1;
    end
    tx_push_req = '0; rx_push_req = '0;
  endtask

  task automatic do_pop(input int f, input int maxw, output bit acked, output int waits,
                        output logic [7:0] d, output logic [7:0] s, output bit vld_ok);
    int c;
    c = f / 2;
    @(posedge clk); #1;
    if (f % 2) rx_pop_req[c] = 1'b1; else tx_pop_req[c] = 1'b1;
    acked = 1'b0; waits = 0; vld_ok = 1'b0; d = '0; s = '0;
    while (!acked && waits < maxw) begin
      @(negedge clk);
      if ((f % 2) ? rx_pop_ack[c] : tx_pop_ack[c]) acked = 1'b1;
      else waits++;
      @(posedge clk); #1;
    end
    tx_pop_req = '0; rx_pop_req = '0;
    if (acked) begin
      @(negedge clk);
      vld_ok = ((f % 2) ? (rx_pop_vld == 3'(1 << c)) : (tx_pop_vld == 3'(1 << c)))
               && ((f % 2) ? (tx_pop_vld == 3'b000) : (rx_pop_vld == 3'b000));
      d = rd_byte; s = rd_stat;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok, vok;
    int w, cap;
    logic [7:0] d, s;
    int cnt [12];

    n_chk = 0; n_bad = 0; done_flag = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_code = '0;
    tx_push_req = '0; tx_pop_req = '0; rx_push_req = '0; rx_pop_req = '0;
    tx_push_data = '0; rx_push_data = '0; rx_push_stat = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_full == 3'b111 && rx_full == 3'b111, "R1 full", int'({tx_full, rx_full}), 63);
    chk(tx_empty == 3'b111 && rx_empty == 3'b111, "R1 empty", int'({tx_empty, rx_empty}), 63);
    chk(tx_level == '0 && rx_level == '0, "R1 level", 1, 0);

    for (int code = 0; code < 16; code++) begin
      set_code(code);
      @(negedge clk);
      for (int f = 0; f < 6; f++) begin
        cap = exp_cap(code, f / 2);
        chk(lvl(f) == 0, "R8 flushed level", lvl(f), 0);
        chk(((f % 2) ? rx_full[f / 2] : tx_full[f / 2]) == (cap == 0),
            (f / 2 == 1) ? "R3 full at zero" : "R2 full at zero",
            int'((f % 2) ? rx_full[f / 2] : tx_full[f / 2]), int'(cap == 0));
        // rotate offsets away from zero (R4 wrap)
        if (cap >= 3) begin
          for (int i = 0; i < 3; i++) begin
            do_push(f, code, i, 8, ok, w);
            chk(ok, "R10 push ack", int'(ok), 1);
          end
          for (int i = 0; i < 3; i++) begin
            do_pop(f, 8, ok, w, d, s, vok);
            chk(ok && d == pat(code, f, i), "R4 rotate order", int'(d), int'(pat(code, f, i)));
          end
        end
        // fill to capacity
        for (int i = 0; i < cap; i++) begin
          do_push(f, code, 3 + i, 8, ok, w);
          chk(ok, "R2 push accepted below capacity", int'(ok), 1);
          chk(w == ((f == 3) ? 1 : 0), "R10 push latency", w, (f == 3) ? 1 : 0);
        end
        @(negedge clk);
        chk(lvl(f) == cap, (f / 2 == 1) ? "R3 capacity" : "R2 capacity", lvl(f), cap);
        chk(((f % 2) ? rx_full[f / 2] : tx_full[f / 2]) == 1'b1, "R2 full flag", 0, 1);
        do_push(f, code, 999, 4, ok, w);
        @(negedge clk);
        chk(!ok && lvl(f) == cap, "R7 push when full ignored", lvl(f), cap);
      end
      // drain all six after all are full (R5)
      for (int f = 0; f < 6; f++) begin
        cap = exp_cap(code, f / 2);
        for (int i = 0; i < cap; i++) begin
          do_pop(f, 8, ok, w, d, s, vok);
          chk(ok && vok, "R10 pop valid next cycle", int'(vok), 1);
          chk(w == ((f == 3) ? 1 : 0), "R10 pop latency", w, (f == 3) ? 1 : 0);
          chk(d == pat(code, f, 3 + i), "R5 data intact", int'(d), int'(pat(code, f, 3 + i)));
          if (f == 3)
            chk(s == ~pat(code, f, 3 + i), "R6 status byte", int'(s), int'(~pat(code, f, 3 + i)));
        end
        do_pop(f, 4, ok, w, d, s, vok);
        @(negedge clk);
        chk(!ok && lvl(f) == 0, "R7 pop when empty ignored", int'(ok), 0);
        // leave two bytes behind for the next flush
        if (cap >= 2) begin
          do_push(f, code, 0, 8, ok, w);
          do_push(f, code, 1, 8, ok, w);
        end
      end
    end

    // R9 round-robin: four continuous requesters on code Bh
    set_code(11);
    for (int k = 0; k < 12; k++) cnt[k] = 0;
    @(posedge clk); #1;
    tx_push_req = 3'b101; rx_push_req = 3'b101;
    for (int cy = 0; cy < 8; cy++) begin
      @(negedge clk);
      chk($countones({tx_push_ack, rx_push_ack}) <= 1, "R9 one access per cycle",
          $countones({tx_push_ack, rx_push_ack}), 1);
      for (int c = 0; c < 3; c++) begin
        if (tx_push_ack[c]) cnt[c]++;
        if (rx_push_ack[c]) cnt[3 + c]++;
      end
      @(posedge clk); #1;
    end
    tx_push_req = '0; rx_push_req = '0;
    chk(cnt[0] == 2, "R9 spi tx share", cnt[0], 2);
    chk(cnt[2] == 2, "R9 i2c tx share", cnt[2], 2);
    chk(cnt[3] == 2, "R9 spi rx share", cnt[3], 2);
    chk(cnt[5] == 2, "R9 i2c rx share", cnt[5], 2);
    // R8: strobe with requests pending acknowledges nothing
    @(posedge clk); #1;
    tx_push_req = 3'b001; cfg_code = 4'hB; cfg_we = 1'b1;
    @(negedge clk);
    chk(tx_push_ack == 3'b000, "R8 no ack during strobe", int'(tx_push_ack), 0);
    @(posedge clk); #1;
    tx_push_req = '0; cfg_we = 1'b0;
    @(negedge clk);
    chk(tx_level[0] == '0 && rx_level[0] == '0, "R8 flush", int'(tx_level[0]), 0);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule